// File: doc/BRIEF.md
# Burst Beat Order Sequencer

This block turns one burst command into eight beat slots on consecutive clocks. For each slot it gives the column index that a double-data-rate memory moves in that slot. The column order depends on four things: the 3-bit start column, whether the command is a read or a write, the burst ordering (sequential or interleaved), and the burst length (full eight-beat or chopped to four). A memory controller uses the slot stream to steer read data into the right buffer positions and to fetch write data in the order the device expects.

Commands enter through a valid/ready handshake and are taken only while the sequencer is idle. The ordering select is meant to be tied off for the whole run. The sequencer samples it once per command, when the command is accepted.

Top module: `burst_order_seq`

## Requirements
- R1: While rst_ni is low, and on the first clock after it rises, cmd_ready_o is 1 and slot_o, beat_valid_o and done_o are 0; an assertion of rst_ni in mid-burst ends the burst at once.
- R2: A command is accepted on a rising clock edge where cmd_valid_i and cmd_ready_o are both 1; slot 0 is presented in the following cycle, and cmd_ready_o stays 0 while slots are presented.
- R3: A sequential read (interleave_i = 0, cmd_write_i = 0) presents, in slot k, the column whose bit 2 is start bit 2 XOR k bit 2 and whose bits 1:0 are (start + k) mod 4; start 3 gives 3,0,1,2,7,4,5,6 and start 5 gives 5,6,7,4,1,2,3,0.
- R4: An interleaved read (interleave_i = 1) presents start XOR k in slot k; start 3 gives 3,2,1,0,7,6,5,4.
- R5: A full-length write (cmd_chop_i = 0, cmd_write_i = 1) presents columns 0 to 7 in ascending order, whatever the start column.
- R6: A chopped write presents columns 0,1,2,3 when start bit 2 is 0, and 4,5,6,7 when it is 1.
- R7: With cmd_chop_i = 1 the burst still takes eight slots; slots 0 to 3 have beat_valid_o = 1 and slots 4 to 7 have beat_valid_o = 0 with beat_col_o = 0. In a full-length burst all eight slots are valid.
- R8: done_o is 1 for exactly one cycle, in slot 7, and cmd_ready_o is 1 in the cycle after it.
- R9: Each accepted command gives exactly eight back-to-back slots, one per clock.
- R10: interleave_i is sampled at acceptance; a change during a burst does not alter the order of that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| interleave_i | input | 1 | Static ordering select: 0 sequential, 1 interleaved |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Sequencer idle, command can be accepted |
| cmd_col_i | input | COL_W | Requested start column |
| cmd_write_i | input | 1 | 1 write, 0 read |
| cmd_chop_i | input | 1 | 1 chopped four-beat burst, 0 full length |
| slot_o | output | 1 | A burst slot is presented this cycle |
| beat_valid_o | output | 1 | The current slot carries data |
| beat_col_o | output | COL_W | Column index of the current slot (0 when not valid) |
| done_o | output | 1 | Last slot of the burst |

## Verification
The end of one burst and the offer of the next command can fall in the same cycle. The bench provokes this by holding cmd_valid_i high with a second command while the first burst is still running. The reference model then expects done_o in slot 7, cmd_ready_o one cycle later, no acceptance while done_o is high, and slot 0 of the second burst in the cycle after acceptance. A separate case changes interleave_i during a burst, and the model requires the ordering sampled at acceptance to hold for the whole burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_SEQ   = 1'b0,
    ORD_INTLV = 1'b1
  } order_e;

  typedef struct packed {
    logic   write;
    logic   chop;
    order_e order;
  } burst_mode_t;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
#(
  parameter int unsigned COL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [COL_W-1:0] cmd_col_i,
  input  burst_mode_t      cmd_mode_i,
  output logic             cmd_ready_o,
  output logic             busy_o,
  output logic [COL_W-1:0] beat_idx_o,
  output logic [COL_W-1:0] start_col_o,
  output burst_mode_t      mode_o,
  output logic             last_o
);
  localparam logic [COL_W-1:0] LastIdx = '1;

  logic             busy_q;
  logic [COL_W-1:0] idx_q;
  logic [COL_W-1:0] start_q;
  burst_mode_t      mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      start_q <= '0;
      mode_q  <= '0;
    end else if (!busy_q) begin
      if (cmd_valid_i) begin
        busy_q  <= 1'b1;
        idx_q   <= '0;
        start_q <= cmd_col_i;
        mode_q  <= cmd_mode_i;
      end
    end else begin
      idx_q <= idx_q + 1'b1;
      if (idx_q == LastIdx) busy_q <= 1'b0;
    end
  end

  assign cmd_ready_o = !busy_q;
  assign busy_o      = busy_q;
  assign beat_idx_o  = idx_q;
  assign start_col_o = start_q;
  assign mode_o      = mode_q;
  assign last_o      = busy_q && (idx_q == LastIdx);
endmodule

// File: rtl/burst_seq_order.sv
module burst_seq_order
  import burst_seq_pkg::*;
#(
  parameter int unsigned COL_W = 3
) (
  input  logic             busy_i,
  input  logic [COL_W-1:0] beat_idx_i,
  input  logic [COL_W-1:0] start_col_i,
  input  burst_mode_t      mode_i,
  output logic             valid_o,
  output logic [COL_W-1:0] col_o
);
  localparam int unsigned LowW = COL_W - 1;

  logic [LowW-1:0]  low_sum;
  logic [COL_W-1:0] seq_col;
  logic [COL_W-1:0] intlv_col;
  logic [COL_W-1:0] wr_col;
  logic [COL_W-1:0] rd_col;
  logic             pad_slot;

  // sequential: wrap within the half-burst group, top bit toggles per group
  assign low_sum   = start_col_i[LowW-1:0] + beat_idx_i[LowW-1:0];
  assign seq_col   = {start_col_i[COL_W-1] ^ beat_idx_i[COL_W-1], low_sum};
  assign intlv_col = start_col_i ^ beat_idx_i;
  assign rd_col    = (mode_i.order == ORD_INTLV) ? intlv_col : seq_col;
  assign wr_col    = mode_i.chop ? {start_col_i[COL_W-1], beat_idx_i[LowW-1:0]}
                                 : beat_idx_i;

  assign pad_slot  = mode_i.chop && beat_idx_i[COL_W-1];
  assign valid_o   = busy_i && !pad_slot;
  assign col_o     = !valid_o ? '0 : (mode_i.write ? wr_col : rd_col);
endmodule

// File: rtl/burst_order_seq.sv
module burst_order_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned COL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             interleave_i,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic [COL_W-1:0] cmd_col_i,
  input  logic             cmd_write_i,
  input  logic             cmd_chop_i,
  output logic             slot_o,
  output logic             beat_valid_o,
  output logic [COL_W-1:0] beat_col_o,
  output logic             done_o
);
  burst_mode_t      cmd_mode;
  burst_mode_t      act_mode;
  logic             busy;
  logic             last;
  logic [COL_W-1:0] beat_idx;
  logic [COL_W-1:0] start_col;

  assign cmd_mode.write = cmd_write_i;
  assign cmd_mode.chop  = cmd_chop_i;
  assign cmd_mode.order = interleave_i ? ORD_INTLV : ORD_SEQ;

  burst_seq_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_col_i   (cmd_col_i),
    .cmd_mode_i  (cmd_mode),
    .cmd_ready_o (cmd_ready_o),
    .busy_o      (busy),
    .beat_idx_o  (beat_idx),
    .start_col_o (start_col),
    .mode_o      (act_mode),
    .last_o      (last)
  );

  burst_seq_order #(.COL_W(COL_W)) u_order (
    .busy_i      (busy),
    .beat_idx_i  (beat_idx),
    .start_col_i (start_col),
    .mode_i      (act_mode),
    .valid_o     (beat_valid_o),
    .col_o       (beat_col_o)
  );

  assign slot_o = busy;
  assign done_o = last;
endmodule

// File: rtl/burst_order_seq_chk.sv
module burst_order_seq_chk #(
  parameter int unsigned COL_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic             cmd_ready_o,
  input logic             slot_o,
  input logic             beat_valid_o,
  input logic [COL_W-1:0] beat_col_o,
  input logic             done_o
);
  localparam logic [COL_W-1:0] LastSlot = '1;

  logic [COL_W-1:0] slot_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      slot_cnt <= '0;
    else if (!slot_o) slot_cnt <= '0;
    else              slot_cnt <= slot_cnt + 1'b1;
  end

  AST_ACCEPT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |=> (slot_o && !cmd_ready_o)); // R2
  AST_READY_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_ready_o && slot_o)); // R2
  AST_VALID_IN_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o |-> slot_o); // R7
  AST_PAD_COL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_o && !beat_valid_o) |-> (beat_col_o == '0)); // R7
  AST_DONE_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (slot_o && slot_cnt == LastSlot)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && cmd_ready_o)); // R8
  AST_SLOTS_CONTIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_o && slot_cnt != LastSlot) |=> slot_o); // R9
endmodule

bind burst_order_seq burst_order_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_valid_i  (cmd_valid_i),
  .cmd_ready_o  (cmd_ready_o),
  .slot_o       (slot_o),
  .beat_valid_o (beat_valid_o),
  .beat_col_o   (beat_col_o),
  .done_o       (done_o)
);

// File: tb/burst_order_seq_bench.sv
`timescale 1ns/1ps
module burst_order_seq_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       interleave_i = 1'b0;
  logic       cmd_valid_i = 1'b0;
  logic [2:0] cmd_col_i = '0;
  logic       cmd_write_i = 1'b0;
  logic       cmd_chop_i = 1'b0;
  logic       cmd_ready_o, slot_o, beat_valid_o, done_o;
  logic [2:0] beat_col_o;

  int checks = 0;
  int errors = 0;
  bit accepted;

  typedef struct {
    bit    slot;
    bit    valid;
    int    col;
    bit    done;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   rec_q[$];

  always #2.5 clk_i = ~clk_i;

  burst_order_seq u_burst_order_seq (
    .clk_i, .rst_ni, .interleave_i, .cmd_valid_i, .cmd_ready_o,
    .cmd_col_i, .cmd_write_i, .cmd_chop_i,
    .slot_o, .beat_valid_o, .beat_col_o, .done_o
  );

  function automatic int ref_col(int s, int k, bit wr, bit ch, bit il);
    if (wr) return ch ? ((s >= 4) ? 4 + k : k) : k;
    if (il) return s ^ k;
    return ((((s / 4) + (k / 4)) % 2) * 4) + ((s + k) % 4);
  endfunction

  task automatic push_burst(int s, bit wr, bit ch, bit il);
    for (int k = 0; k < 8; k++) begin
      exp_t e;
      e.slot  = 1'b1;
      e.valid = !(ch && k >= 4);
      e.col   = e.valid ? ref_col(s, k, wr, ch, il) : 0;
      e.done  = (k == 7);
      if (k == 7)      e.tag = "R8";
      else if (!e.valid) e.tag = "R7";
      else if (wr)     e.tag = ch ? "R6" : "R5";
      else             e.tag = il ? "R4" : "R3";
      exp_q.push_back(e);
    end
  endtask

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // one clock: accept decision on current inputs, then compare at the next falling edge
  task automatic tick();
    exp_t e;
    accepted = cmd_valid_i && cmd_ready_o;
    if (accepted) push_burst(cmd_col_i, cmd_write_i, cmd_chop_i, interleave_i);
    @(negedge clk_i);
    if (exp_q.size() > 0) e = exp_q.pop_front();
    else begin
      e.slot = 0; e.valid = 0; e.col = 0; e.done = 0; e.tag = "R2";
    end
    check(slot_o == e.slot && cmd_ready_o == !e.slot && beat_valid_o == e.valid &&
          int'(beat_col_o) == e.col && done_o == e.done, e.tag,
          "slot/ready/valid/col/done",
          {slot_o, cmd_ready_o, beat_valid_o, done_o, 4'(beat_col_o)},
          {e.slot, !e.slot, e.valid, e.done, 4'(e.col)});
    if (slot_o && beat_valid_o) rec_q.push_back(int'(beat_col_o));
  endtask

  task automatic issue(int s, bit wr, bit ch);
    cmd_col_i = 3'(s); cmd_write_i = wr; cmd_chop_i = ch; cmd_valid_i = 1'b1;
    do tick(); while (!accepted);
    cmd_valid_i = 1'b0;
    while (exp_q.size() > 0) tick();
    tick();
  endtask

  task automatic check_order(string tag, int exp_arr[8]);
    check(rec_q.size() == 8, tag, "recorded beats", rec_q.size(), 8);
    for (int i = 0; i < 8 && i < rec_q.size(); i++)
      check(rec_q[i] == exp_arr[i], tag, $sformatf("beat %0d column", i), rec_q[i], exp_arr[i]);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    // R1: reset state
    #1;
    check(cmd_ready_o == 1 && slot_o == 0 && done_o == 0 && beat_valid_o == 0, "R1",
          "in reset", {cmd_ready_o, slot_o, done_o}, 3'b100);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    tick();

    // R3 / R4 stated orders
    interleave_i = 1'b0; rec_q.delete(); issue(3, 0, 0);
    check_order("R3", '{3, 0, 1, 2, 7, 4, 5, 6});
    rec_q.delete(); issue(5, 0, 0);
    check_order("R3", '{5, 6, 7, 4, 1, 2, 3, 0});
    interleave_i = 1'b1; rec_q.delete(); issue(3, 0, 0);
    check_order("R4", '{3, 2, 1, 0, 7, 6, 5, 4});

    // R3..R9 sweep: all starts, orderings, lengths, directions
    for (int il = 0; il < 2; il++)
      for (int s = 0; s < 8; s++)
        for (int ch = 0; ch < 2; ch++)
          for (int wr = 0; wr < 2; wr++) begin
            interleave_i = il[0];
            issue(s, wr[0], ch[0]);
          end

    // R10: ordering change mid-burst is ignored
    interleave_i = 1'b0; rec_q.delete();
    cmd_col_i = 3'd3; cmd_write_i = 0; cmd_chop_i = 0; cmd_valid_i = 1;
    do tick(); while (!accepted);
    cmd_valid_i = 0; tick(); tick();
    interleave_i = 1'b1;
    while (exp_q.size() > 0) tick();
    check_order("R10", '{3, 0, 1, 2, 7, 4, 5, 6});
    tick();

    // R8 / R2: next command held pending across done
    interleave_i = 1'b0;
    cmd_col_i = 3'd6; cmd_write_i = 0; cmd_chop_i = 1; cmd_valid_i = 1;
    do tick(); while (!accepted);
    cmd_col_i = 3'd5; cmd_write_i = 1; cmd_chop_i = 1;
    do tick(); while (!accepted);
    cmd_valid_i = 0;
    while (exp_q.size() > 0) tick();
    tick();

    // R1: reset in mid-burst
    cmd_col_i = 3'd2; cmd_write_i = 0; cmd_chop_i = 0; cmd_valid_i = 1;
    do tick(); while (!accepted);
    cmd_valid_i = 0; tick(); tick();
    rst_ni = 1'b0; #1;
    check(cmd_ready_o == 1 && slot_o == 0 && done_o == 0 && beat_valid_o == 0, "R1",
          "mid-burst reset", {cmd_ready_o, slot_o, done_o}, 3'b100);
    exp_q.delete();
    @(negedge clk_i); rst_ni = 1'b1;
    tick(); tick();
    interleave_i = 1'b1; issue(6, 0, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule